// File: doc/BRIEF.md
# System Bus Master Arbitration Controller

This block lets a local processor take mastership of a shared, multi-master system bus. The processor's read and write strobes are qualified into a single command. When the address decode marks the access as off-board, the controller requests the bus. It can sit in a serial daisy chain through its priority-out output, or on a central parallel resolver through its request output.

Once priority-in grants the bus and no other master still holds the shared busy line, the controller seizes the bus. It pulls its own busy and the address/data driver enable low, then issues the bus read or write command. The command is held until the addressed slave acknowledges. Busy and the enable are released one bus-clock edge after that.

Every register works on the falling edge of the bus clock. All bus-side signals are active low.

Top module: `sysbus_master`

## Requirements
- R1: While reset is active, breq_n, busy_n, aden_n, rdc_n, wrc_n and qcmd_n are all high, and prio_out_n equals prio_in_n.
- R2: qcmd_n goes low as soon as cpu_rd is high. For cpu_wr it goes low only after the first falling clock edge at which cpu_wr was sampled high. It returns high as soon as the strobe drops.
- R3: If off_board is low, the controller does not arbitrate: breq_n and busy_n stay high even while qcmd_n is low.
- R4: At the first falling edge with qcmd_n low and off_board high, breq_n goes low and prio_out_n goes high. Both are held until the bus is released. While breq_n is high, prio_out_n equals prio_in_n.
- R5: While requesting, a falling edge that samples prio_in_n low and busy_in_n high is the grant. busy_n and aden_n go low on the next falling edge. While busy_in_n is low, or prio_in_n is high, the controller keeps waiting with busy_n high.
- R6: One falling edge after aden_n goes low, rdc_n goes low for a read or wrc_n goes low for a write. cpu_rd wins if both strobes are high. rdc_n and wrc_n are never low together.
- R7: The command stays low until a falling edge samples xack_n low, which raises it. busy_n, aden_n and breq_n go high on the following falling edge.
- R8: While the controller owns the bus, changes on prio_in_n or busy_in_n do not release it. busy_n, aden_n, breq_n and the command hold until the acknowledge.
- R9: If the qualified off-board command goes away before the grant, breq_n returns high at the next falling edge and busy_n is never asserted.
- R10: addr_xmit is high (address drivers transmit) exactly when slave_mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; falling edge is the timing reference |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | Processor read strobe, active high |
| cpu_wr | input | 1 | Processor write strobe, active high |
| off_board | input | 1 | Address decode: access targets the system bus |
| slave_mode | input | 1 | Board is being accessed as a bus slave |
| prio_in_n | input | 1 | Bus priority input, low grants |
| busy_in_n | input | 1 | Shared bus busy line as sensed, low while any master holds the bus |
| xack_n | input | 1 | Transfer acknowledge from the slave, active low |
| qcmd_n | output | 1 | Qualified command, active low |
| breq_n | output | 1 | Bus request for parallel resolution, active low |
| prio_out_n | output | 1 | Priority output to the next master in a serial chain |
| busy_n | output | 1 | Busy driven by this master, active low |
| aden_n | output | 1 | Address/data driver enable, active low |
| rdc_n | output | 1 | Bus read command, active low |
| wrc_n | output | 1 | Bus write command, active low |
| addr_xmit | output | 1 | Address driver direction, high = transmit |

## Verification
The bench times the write qualification against the read path. A design that skipped the half-clock write delay would show qcmd_n low right after the write strobe, and would request the bus one edge too early. It holds busy_in_n low across a grant, to catch a controller that seizes a bus another master still owns. It also toggles priority and busy during an owned transfer, to catch one that gives the bus up before the acknowledge. It places the command one edge behind the enable and the release one edge behind the acknowledge. It checks that an on-board access, or a request withdrawn before the grant, never asserts busy, and that priority-out follows priority-in whenever the controller is idle.

// File: rtl/sysbus_master.sv
module sysbus_master (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_rd,
  input  logic cpu_wr,
  input  logic off_board,
  input  logic slave_mode,
  input  logic prio_in_n,
  input  logic busy_in_n,
  input  logic xack_n,
  output logic qcmd_n,
  output logic breq_n,
  output logic prio_out_n,
  output logic busy_n,
  output logic aden_n,
  output logic rdc_n,
  output logic wrc_n,
  output logic addr_xmit
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_GRANT = 3'd2,
    S_OWN   = 3'd3,
    S_CMD   = 3'd4,
    S_REL   = 3'd5
  } state_t;

  state_t st;
  logic   wr_late;
  logic   is_wr;
  logic   qcmd;
  logic   go;
  logic   owned;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) wr_late <= 1'b0;
    else        wr_late <= cpu_wr;

  assign qcmd = cpu_rd | (cpu_wr & wr_late);
  assign go   = qcmd & off_board;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_wr <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (go) begin
                   st    <= S_REQ;
                   is_wr <= ~cpu_rd;
                 end
        S_REQ:   if (!go)                        st <= S_IDLE;
                 else if (!prio_in_n && busy_in_n) st <= S_GRANT;
        S_GRANT: st <= S_OWN;
        S_OWN:   st <= S_CMD;
        S_CMD:   if (!xack_n) st <= S_REL;
        S_REL:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign owned      = (st == S_OWN) || (st == S_CMD) || (st == S_REL);
  assign qcmd_n     = ~qcmd;
  assign breq_n     = (st == S_IDLE);
  assign prio_out_n = (st == S_IDLE) ? prio_in_n : 1'b1;
  assign busy_n     = ~owned;
  assign aden_n     = ~owned;
  assign rdc_n      = ~((st == S_CMD) && !is_wr);
  assign wrc_n      = ~((st == S_CMD) && is_wr);
  assign addr_xmit  = ~slave_mode;

endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic off_board,
  input logic prio_in_n,
  input logic busy_in_n,
  input logic xack_n,
  input logic qcmd_n,
  input logic breq_n,
  input logic prio_out_n,
  input logic busy_n,
  input logic aden_n,
  input logic rdc_n,
  input logic wrc_n
);

  AST_ONE_CMD: assert property (@(negedge clk) disable iff (!rst_n)
    !(!rdc_n && !wrc_n)); // R6

  AST_CMD_AFTER_EN: assert property (@(negedge clk) disable iff (!rst_n)
    ($fell(rdc_n) || $fell(wrc_n)) |-> $past(!aden_n)); // R6

  AST_CMD_OWNED: assert property (@(negedge clk) disable iff (!rst_n)
    (!rdc_n || !wrc_n) |-> (!busy_n && !aden_n && !breq_n)); // R8

  AST_RELEASE_IDLE_CMD: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(rdc_n && wrc_n)); // R7

  AST_RELEASE_AFTER_ACK: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(!xack_n, 2)); // R7

  AST_BUSY_AFTER_GRANT: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(!prio_in_n, 2) && $past(busy_in_n, 2))); // R5

  AST_REQ_OFFBOARD: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(breq_n) |-> $past(!qcmd_n && off_board)); // R3

  AST_PRIO_PASS: assert property (@(negedge clk) disable iff (!rst_n)
    breq_n |-> (prio_out_n == prio_in_n)); // R4

  AST_PRIO_BLOCK: assert property (@(negedge clk) disable iff (!rst_n)
    !breq_n |-> prio_out_n); // R4

endmodule

bind sysbus_master sysbus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .off_board(off_board), .prio_in_n(prio_in_n),
  .busy_in_n(busy_in_n), .xack_n(xack_n), .qcmd_n(qcmd_n), .breq_n(breq_n),
  .prio_out_n(prio_out_n), .busy_n(busy_n), .aden_n(aden_n),
  .rdc_n(rdc_n), .wrc_n(wrc_n)
);

// File: tb/sysbus_master_tb.sv
module sysbus_master_tb;
  logic clk = 1'b1;
  logic rst_n = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, off_board = 1'b0, slave_mode = 1'b0;
  logic prio_in_n = 1'b0, busy_in_n = 1'b1, xack_n = 1'b1;
  logic qcmd_n, breq_n, prio_out_n, busy_n, aden_n, rdc_n, wrc_n, addr_xmit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .off_board(off_board), .slave_mode(slave_mode), .prio_in_n(prio_in_n),
    .busy_in_n(busy_in_n), .xack_n(xack_n), .qcmd_n(qcmd_n), .breq_n(breq_n),
    .prio_out_n(prio_out_n), .busy_n(busy_n), .aden_n(aden_n),
    .rdc_n(rdc_n), .wrc_n(wrc_n), .addr_xmit(addr_xmit)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk("R1", "breq_n", breq_n, 1'b1);
    chk("R1", "busy_n", busy_n, 1'b1);
    chk("R1", "aden_n", aden_n, 1'b1);
    chk("R1", "rdc_n", rdc_n, 1'b1);
    chk("R1", "wrc_n", wrc_n, 1'b1);
    chk("R1", "qcmd_n", qcmd_n, 1'b1);
    prio_in_n = 1'b0; #1;
    chk("R1", "prio_out_n pass low", prio_out_n, 1'b0);
    prio_in_n = 1'b1; #1;
    chk("R1", "prio_out_n pass high", prio_out_n, 1'b1);
    prio_in_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_read();
    cpu_rd = 1'b1; off_board = 1'b1; #1;
    chk("R2", "read qcmd_n immediate", qcmd_n, 1'b0);
    tick();
    chk("R4", "breq_n on request", breq_n, 1'b0);
    chk("R4", "prio_out_n blocks", prio_out_n, 1'b1);
    chk("R5", "busy_n before grant", busy_n, 1'b1);
    tick();
    chk("R5", "busy_n at grant edge", busy_n, 1'b1);
    tick();
    chk("R5", "busy_n after grant", busy_n, 1'b0);
    chk("R5", "aden_n after grant", aden_n, 1'b0);
    chk("R6", "rdc_n not with enable", rdc_n, 1'b1);
    tick();
    chk("R6", "rdc_n asserted", rdc_n, 1'b0);
    chk("R6", "wrc_n idle on read", wrc_n, 1'b1);
    tick();
    chk("R7", "rdc_n held without ack", rdc_n, 1'b0);
    xack_n = 1'b0; cpu_rd = 1'b0; off_board = 1'b0;
    tick();
    chk("R7", "rdc_n removed on ack", rdc_n, 1'b1);
    chk("R7", "busy_n held after ack", busy_n, 1'b0);
    xack_n = 1'b1;
    tick();
    chk("R7", "busy_n released", busy_n, 1'b1);
    chk("R7", "aden_n released", aden_n, 1'b1);
    chk("R7", "breq_n released", breq_n, 1'b1);
    chk("R4", "prio_out_n passes after release", prio_out_n, prio_in_n);
    tick();
  endtask

  task automatic t_write();
    cpu_wr = 1'b1; off_board = 1'b1; #1;
    chk("R2", "write qcmd_n delayed", qcmd_n, 1'b1);
    tick();
    chk("R2", "write qcmd_n after edge", qcmd_n, 1'b0);
    chk("R4", "breq_n not yet for write", breq_n, 1'b1);
    tick();
    chk("R4", "breq_n for write", breq_n, 1'b0);
    tick();
    chk("R5", "write busy_n at grant edge", busy_n, 1'b1);
    tick();
    chk("R5", "write busy_n after grant", busy_n, 1'b0);
    tick();
    chk("R6", "wrc_n asserted", wrc_n, 1'b0);
    chk("R6", "rdc_n idle on write", rdc_n, 1'b1);
    xack_n = 1'b0; cpu_wr = 1'b0; off_board = 1'b0; #1;
    chk("R2", "qcmd_n drops with strobe", qcmd_n, 1'b1);
    tick();
    chk("R7", "wrc_n removed on ack", wrc_n, 1'b1);
    xack_n = 1'b1;
    tick();
    chk("R7", "write busy_n released", busy_n, 1'b1);
    tick();
  endtask

  task automatic t_onboard();
    cpu_rd = 1'b1; off_board = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3", "qcmd_n on-board", qcmd_n, 1'b0);
      chk("R3", "breq_n on-board", breq_n, 1'b1);
      chk("R3", "busy_n on-board", busy_n, 1'b1);
    end
    cpu_rd = 1'b0;
    tick();
  endtask

  task automatic t_busy_wait_and_hold();
    busy_in_n = 1'b0;
    cpu_rd = 1'b1; off_board = 1'b1;
    tick();
    chk("R5", "breq_n while bus busy", breq_n, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R5", "busy_n waits for other master", busy_n, 1'b1);
    end
    busy_in_n = 1'b1;
    tick();
    chk("R5", "busy_n at grant edge after wait", busy_n, 1'b1);
    tick();
    chk("R5", "busy_n after wait", busy_n, 1'b0);
    tick();
    chk("R6", "rdc_n after wait", rdc_n, 1'b0);
    prio_in_n = 1'b1; busy_in_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8", "busy_n held", busy_n, 1'b0);
      chk("R8", "aden_n held", aden_n, 1'b0);
      chk("R8", "rdc_n held", rdc_n, 1'b0);
      chk("R8", "breq_n held", breq_n, 1'b0);
    end
    xack_n = 1'b0; cpu_rd = 1'b0; off_board = 1'b0;
    tick();
    chk("R7", "rdc_n removed", rdc_n, 1'b1);
    xack_n = 1'b1;
    tick();
    chk("R7", "busy_n released after hold", busy_n, 1'b1);
    chk("R4", "prio_out_n passes high", prio_out_n, 1'b1);
    prio_in_n = 1'b0; busy_in_n = 1'b1;
    tick();
  endtask

  task automatic t_drop();
    prio_in_n = 1'b1;
    cpu_rd = 1'b1; off_board = 1'b1;
    tick();
    chk("R9", "breq_n while waiting", breq_n, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", "busy_n without priority", busy_n, 1'b1);
    end
    cpu_rd = 1'b0; off_board = 1'b0;
    tick();
    chk("R9", "breq_n after withdraw", breq_n, 1'b1);
    chk("R9", "busy_n after withdraw", busy_n, 1'b1);
    prio_in_n = 1'b0;
    tick();
    chk("R9", "busy_n stays high", busy_n, 1'b1);
    chk("R9", "breq_n stays high", breq_n, 1'b1);
  endtask

  task automatic t_slave();
    slave_mode = 1'b1; #1;
    chk("R10", "addr_xmit in slave mode", addr_xmit, 1'b0);
    slave_mode = 1'b0; #1;
    chk("R10", "addr_xmit as master", addr_xmit, 1'b1);
  endtask

  initial begin
    #5;
    t_reset();
    t_read();
    t_write();
    t_onboard();
    t_busy_wait_and_hold();
    t_drop();
    t_slave();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule